// File: doc/BRIEF.md
# Bus clock prescaler with timer doubling

This block turns one free-running system clock into a set of single-cycle enable strobes, one for the CPU bus and one for each of two peripheral buses. Each rate is set by a small prescaler code. The peripheral buses are divided down from the CPU-bus strobe, not from the system clock, so every peripheral strobe falls on a CPU-bus strobe. For each peripheral bus a timer strobe is also produced. It equals the bus strobe when that bus runs undivided, and runs at twice the bus rate whenever the bus prescaler divides.

Every output is an enable in the system-clock domain, meant to qualify flops that run on the system clock. A code may be changed at any time. The new value is taken up only when the running period completes, so no shortened period ever appears. Codes are first sampled in the cycle after reset is released. All strobes stay low in that cycle.

Top module: `busclk_prescale`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released (the load cycle), all five strobes are low. The codes present in the load cycle set the first divide ratios.
- R2: The CPU-bus code is 4 bits. Any code with bit 3 clear divides by 1, which holds the CPU-bus strobe high in every cycle. Code 4'b1000 divides by 2, 4'b1001 by 4, 4'b1010 by 8, 4'b1011 by 16, 4'b1100 by 64, 4'b1101 by 128, 4'b1110 by 256 and 4'b1111 by 512. With divide ratio D, the strobe is high in cycles D, 2D, 3D and so on, counted from the load cycle as cycle 0.
- R3: Each peripheral-bus code is 3 bits. Any code with bit 2 clear divides by 1. Code 3'b100 divides by 2, 3'b101 by 4, 3'b110 by 8 and 3'b111 by 16.
- R4: Each peripheral-bus strobe counts CPU-bus strobes. With ratio P, it is high on every P-th CPU-bus strobe and never in a cycle without a CPU-bus strobe, so its period is D×P system cycles.
- R5: With peripheral ratio 1, the timer strobe equals that bus strobe. With ratio P>1, the timer strobe is high on every bus strobe and also on the CPU-bus strobe halfway between two bus strobes. This gives a period of D×P/2 cycles.
- R6: A code change takes effect only at the end of the period in progress. The strobe that closes the current period comes at the old spacing, and later periods use the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ahb_div_code | input | 4 | CPU-bus prescaler code |
| apb1_div_code | input | 3 | Prescaler code for peripheral bus 1 |
| apb2_div_code | input | 3 | Prescaler code for peripheral bus 2 |
| hclk_en | output | 1 | CPU-bus enable strobe |
| pclk1_en | output | 1 | Peripheral bus 1 enable strobe |
| pclk2_en | output | 1 | Peripheral bus 2 enable strobe |
| tim1_en | output | 1 | Timer enable strobe for peripheral bus 1 |
| tim2_en | output | 1 | Timer enable strobe for peripheral bus 2 |

## Verification
Every CPU-bus code is run once with both peripheral buses undivided. This separates the non-linear ladder, including the skipped divide-by-32, from the peripheral logic. Every peripheral code is then run with the CPU bus undivided, using opposite codes on the two buses so that a swapped decode or crossed channels shows up. Combined ratios (CPU bus divided and peripheral buses divided together) show that peripheral periods multiply rather than add, and that the timer midpoint lands on a CPU-bus strobe. A live code change partway through a period, plus codes whose top bit is clear but whose low bits are set, cover when a ratio is taken up and the don't-care bits of the divide-by-1 codes.

// File: rtl/busclk_pkg.sv
package busclk_pkg;
  localparam int AHB_CODE_W = 4;
  localparam int APB_CODE_W = 3;
  localparam int AHB_SH_W   = 4;   // shift amount 0..9
  localparam int APB_SH_W   = 3;   // shift amount 0..4
  localparam int AHB_CNT_W  = 9;   // up to 512 cycles
  localparam int APB_CNT_W  = 4;   // up to 16 bus strobes
  localparam int APB_COUNT  = 2;

  // CPU-bus code to power-of-two exponent; the ladder skips 2^5
  function automatic logic [AHB_SH_W-1:0] ahb_code_to_shift(logic [AHB_CODE_W-1:0] code);
    logic [AHB_SH_W-1:0] sh;
    if (!code[AHB_CODE_W-1]) begin
      sh = '0;
    end else begin
      case (code[AHB_CODE_W-2:0])
        3'd0:    sh = 4'd1;
        3'd1:    sh = 4'd2;
        3'd2:    sh = 4'd3;
        3'd3:    sh = 4'd4;
        3'd4:    sh = 4'd6;
        3'd5:    sh = 4'd7;
        3'd6:    sh = 4'd8;
        default: sh = 4'd9;
      endcase
    end
    return sh;
  endfunction

  // Peripheral-bus code to exponent: top bit clear means 2^0
  function automatic logic [APB_SH_W-1:0] apb_code_to_shift(logic [APB_CODE_W-1:0] code);
    logic [APB_SH_W-1:0] sh;
    if (!code[APB_CODE_W-1]) sh = '0;
    else                     sh = {1'b0, code[APB_CODE_W-2:0]} + 3'd1;
    return sh;
  endfunction

  // Terminal count for a divide by 2^sh
  function automatic logic [15:0] low_mask(logic [7:0] sh);
    return (16'd1 << sh) - 16'd1;
  endfunction
endpackage

// File: rtl/busclk_divcnt.sv
module busclk_divcnt #(
  parameter int CNT_W = 9,
  parameter int SH_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [SH_W-1:0] next_sh,
  output logic [SH_W-1:0] cur_sh,
  output logic            wrap,
  output logic            half_hit
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] hlim;

  always_comb begin
    lim      = CNT_W'(busclk_pkg::low_mask(8'(cur_sh)));
    hlim     = lim >> 1;
    wrap     = (cnt == lim);
    // true at the middle of the period and at its end; always true when undivided
    half_hit = ((cnt & hlim) == hlim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      cur_sh <= '0;
    end else if (tick) begin
      if (wrap) begin
        cnt    <= '0;
        cur_sh <= next_sh;   // ratio taken up only at period end
      end else begin
        cnt    <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/busclk_prescale.sv
module busclk_prescale
  import busclk_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AHB_CODE_W-1:0] ahb_div_code,
  input  logic [APB_CODE_W-1:0] apb1_div_code,
  input  logic [APB_CODE_W-1:0] apb2_div_code,
  output logic                  hclk_en,
  output logic                  pclk1_en,
  output logic                  pclk2_en,
  output logic                  tim1_en,
  output logic                  tim2_en
);
  logic                run;
  logic [AHB_SH_W-1:0] ahb_next;
  logic [AHB_SH_W-1:0] ahb_sh;
  logic                ahb_wrap;
  logic                ahb_half_unused;

  logic [APB_CODE_W-1:0] apb_code [APB_COUNT];
  logic [APB_SH_W-1:0]   apb_next [APB_COUNT];
  logic [APB_SH_W-1:0]   apb_sh   [APB_COUNT];
  logic [APB_COUNT-1:0]  apb_wrap;
  logic [APB_COUNT-1:0]  apb_half;
  logic [APB_COUNT-1:0]  pclk_v;
  logic [APB_COUNT-1:0]  tim_v;

  // First cycle after reset only loads the codes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= 1'b1;
  end

  assign ahb_next = ahb_code_to_shift(ahb_div_code);

  busclk_divcnt #(.CNT_W(AHB_CNT_W), .SH_W(AHB_SH_W)) u_ahb (
    .clk(clk), .rst_n(rst_n), .tick(1'b1), .next_sh(ahb_next),
    .cur_sh(ahb_sh), .wrap(ahb_wrap), .half_hit(ahb_half_unused)
  );

  assign apb_code[0] = apb1_div_code;
  assign apb_code[1] = apb2_div_code;

  for (genvar i = 0; i < APB_COUNT; i++) begin : g_apb
    assign apb_next[i] = apb_code_to_shift(apb_code[i]);

    busclk_divcnt #(.CNT_W(APB_CNT_W), .SH_W(APB_SH_W)) u_apb (
      .clk(clk), .rst_n(rst_n), .tick(ahb_wrap), .next_sh(apb_next[i]),
      .cur_sh(apb_sh[i]), .wrap(apb_wrap[i]), .half_hit(apb_half[i])
    );

    // bus strobes counted in CPU-bus strobes, so always aligned to them
    assign pclk_v[i] = run & ahb_wrap & apb_wrap[i];
    assign tim_v[i]  = run & ahb_wrap & apb_half[i];
  end

  assign hclk_en  = run & ahb_wrap;
  assign pclk1_en = pclk_v[0];
  assign pclk2_en = pclk_v[1];
  assign tim1_en  = tim_v[0];
  assign tim2_en  = tim_v[1];
endmodule

// File: rtl/busclk_prescale_chk.sv
module busclk_prescale_chk
  import busclk_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                run,
  input logic                ahb_wrap,
  input logic [AHB_SH_W-1:0] ahb_sh,
  input logic [APB_SH_W-1:0] apb1_sh,
  input logic [APB_SH_W-1:0] apb2_sh,
  input logic                hclk_en,
  input logic                pclk1_en,
  input logic                pclk2_en,
  input logic                tim1_en,
  input logic                tim2_en
);
  AST_QUIET_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(hclk_en || pclk1_en || pclk2_en || tim1_en || tim2_en)); // R1
  AST_HCLK_FLAT_DIV1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ahb_sh == '0) |-> hclk_en); // R2
  AST_PCLK1_FLAT_DIV1: assert property (@(posedge clk) disable iff (!rst_n)
    (apb1_sh == '0 && hclk_en) |-> pclk1_en); // R3
  AST_PCLK_ON_HCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk1_en || pclk2_en || tim1_en || tim2_en) |-> hclk_en); // R4
  AST_TIM1_COVERS_PCLK: assert property (@(posedge clk) disable iff (!rst_n)
    pclk1_en |-> tim1_en); // R5
  AST_TIM2_COVERS_PCLK: assert property (@(posedge clk) disable iff (!rst_n)
    pclk2_en |-> tim2_en); // R5
  AST_TIM2_SAME_DIV1: assert property (@(posedge clk) disable iff (!rst_n)
    (apb2_sh == '0) |-> (tim2_en == pclk2_en)); // R5
  AST_AHB_SWITCH_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !ahb_wrap |=> $stable(ahb_sh)); // R6
  AST_APB_SWITCH_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !ahb_wrap |=> ($stable(apb1_sh) && $stable(apb2_sh))); // R6
endmodule

bind busclk_prescale busclk_prescale_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .ahb_wrap(ahb_wrap), .ahb_sh(ahb_sh),
  .apb1_sh(apb_sh[0]), .apb2_sh(apb_sh[1]),
  .hclk_en(hclk_en), .pclk1_en(pclk1_en), .pclk2_en(pclk2_en),
  .tim1_en(tim1_en), .tim2_en(tim2_en)
);

// File: tb/busclk_prescale_tb.sv
`timescale 1ns/1ps
module busclk_prescale_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ahb_c = 4'b0000;
  logic [2:0] apbc [2];
  logic hclk_en, pclk1_en, pclk2_en, tim1_en, tim2_en;

  always #4 clk = ~clk;   // 125 MHz

  initial begin
    apbc[0] = 3'b000;
    apbc[1] = 3'b000;
  end

  busclk_prescale u_dut (
    .clk(clk), .rst_n(rst_n), .ahb_div_code(ahb_c),
    .apb1_div_code(apbc[0]), .apb2_div_code(apbc[1]),
    .hclk_en(hclk_en), .pclk1_en(pclk1_en), .pclk2_en(pclk2_en),
    .tim1_en(tim1_en), .tim2_en(tim2_en)
  );

  typedef struct { logic [4:0] exp; string tag; int cyc; } item_t;
  item_t q[$];
  item_t mon_it;
  int checks = 0;
  int fails  = 0;
  int cyc_no = 0;
  bit done   = 0;

  // scoreboard model state: cycles / CPU-bus strobes left until the next strobe
  int m_hdiv, m_hleft;
  int m_pdiv [2];
  int m_pleft [2];

  function automatic int ahb_ratio(logic [3:0] c);
    int r;
    case (c)
      4'b1000: r = 2;    4'b1001: r = 4;    4'b1010: r = 8;
      4'b1011: r = 16;   4'b1100: r = 64;   4'b1101: r = 128;
      4'b1110: r = 256;  4'b1111: r = 512;
      default: r = 1;
    endcase
    return r;
  endfunction

  function automatic int apb_ratio(logic [2:0] c);
    if (c < 3'd4) return 1;
    return 2 ** (int'(c) - 3);
  endfunction

  task automatic next_cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic push(logic [4:0] e, string t);
    item_t it;
    it.exp = e;
    it.tag = t;
    it.cyc = cyc_no;
    cyc_no++;
    q.push_back(it);
  endtask

  task automatic drain();
    wait (q.size() == 0);
  endtask

  task automatic model_load();
    m_hdiv  = ahb_ratio(ahb_c);
    m_hleft = m_hdiv;
    for (int i = 0; i < 2; i++) begin
      m_pdiv[i]  = apb_ratio(apbc[i]);
      m_pleft[i] = m_pdiv[i];
    end
  endtask

  task automatic expect_cycles(int n, string t);
    for (int k = 0; k < n; k++) begin
      logic h;
      logic [1:0] p, tm;
      h = (m_hleft == 1);
      p = '0;
      tm = '0;
      if (h) begin
        for (int i = 0; i < 2; i++) begin
          p[i]  = (m_pleft[i] == 1);
          tm[i] = p[i] || (m_pdiv[i] > 1 && m_pleft[i] == m_pdiv[i] / 2 + 1);
          if (p[i]) begin
            m_pdiv[i]  = apb_ratio(apbc[i]);
            m_pleft[i] = m_pdiv[i];
          end else begin
            m_pleft[i]--;
          end
        end
        m_hdiv  = ahb_ratio(ahb_c);
        m_hleft = m_hdiv;
      end else begin
        m_hleft--;
      end
      push({h, p[0], p[1], tm[0], tm[1]}, t);
    end
  endtask

  task automatic do_reset(logic [3:0] a, logic [2:0] b1, logic [2:0] b2);
    next_cycle();
    rst_n = 1'b0;
    ahb_c = a;
    apbc[0] = b1;
    apbc[1] = b2;
    for (int k = 0; k < 3; k++) push(5'b0, "R1 reset");
    drain();
    next_cycle();
    rst_n = 1'b1;
    cyc_no = 0;
    model_load();
    push(5'b0, "R1 load");
    drain();
  endtask

  task automatic run_phase(logic [3:0] a, logic [2:0] b1, logic [2:0] b2, int n, string t);
    next_cycle();
    ahb_c = a;
    apbc[0] = b1;
    apbc[1] = b2;
    expect_cycles(n, t);
    drain();
  endtask

  // monitor: compares one cycle of strobes per queued item, away from the edge
  always @(negedge clk) begin
    if (q.size() != 0) begin
      mon_it = q.pop_front();
      checks++;
      if ({hclk_en, pclk1_en, pclk2_en, tim1_en, tim2_en} !== mon_it.exp) begin
        fails++;
        $display("FAIL %s cycle %0d: {h,p1,p2,t1,t2} actual %b expected %b",
                 mon_it.tag, mon_it.cyc,
                 {hclk_en, pclk1_en, pclk2_en, tim1_en, tim2_en}, mon_it.exp);
      end
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state, then R2 divide-by-1 with every strobe held high
    do_reset(4'b0000, 3'b000, 3'b000);
    run_phase(4'b0000, 3'b000, 3'b000, 8, "R2 div1");
    // low bits set under a clear top bit still mean divide by 1 (R2, R3)
    run_phase(4'b0111, 3'b011, 3'b010, 8, "R3 topbit-clear");
    // R2: whole CPU-bus ladder, 1011 gives 16 and 1100 gives 64
    for (int c = 8; c < 16; c++) begin
      do_reset(4'(c), 3'b000, 3'b000);
      run_phase(4'(c), 3'b000, 3'b000, 2 * ahb_ratio(4'(c)) + 3, "R2 ladder");
    end
    // R3 and R5: peripheral ladder, opposite codes on the two buses
    for (int c = 4; c < 8; c++) begin
      do_reset(4'b0000, 3'(c), 3'(11 - c));
      run_phase(4'b0000, 3'(c), 3'(11 - c), 35, "R3 apb ladder");
    end
    // R4: ratios multiply, strobes aligned to CPU-bus strobes
    do_reset(4'b1001, 3'b111, 3'b110);
    run_phase(4'b1001, 3'b111, 3'b110, 150, "R4 product");
    // R5: timer doubling with a divided CPU bus, other bus undivided
    do_reset(4'b1000, 3'b101, 3'b000);
    run_phase(4'b1000, 3'b101, 3'b000, 40, "R5 timer");
    // R6: live changes mid-period
    do_reset(4'b1001, 3'b000, 3'b100);
    run_phase(4'b1001, 3'b000, 3'b100, 10, "R6 before");
    run_phase(4'b1011, 3'b000, 3'b110, 90, "R6 after");
    run_phase(4'b1000, 3'b101, 3'b000, 60, "R6 back");
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule